// File: doc/BRIEF.md
# Dual-Port Message Acknowledge Tracker

This block follows one outgoing message until the far-end receivers on two redundant link ports (A and B) confirm receipt. Each port has an enable bit that says whether its far end must confirm. Each port also has a select field that picks one of several incoming status lines as its confirmation line. A confirmation counts on a rising edge of the selected line, and only after the message has been sent. Once every enabled port has confirmed, the transmit-buffer-ready flag rises and stays up until the next message starts.

The block also keeps a receive-buffer-full flag for each port. A message arrival sets it and a consumer read clears it. It is forced to zero while its port is disabled. When both ports are disabled the whole channel is inert: every flag reads zero, and start, done and arrival strobes have no effect.

Top module: `msg_ack_tracker`

## Requirements
- R1: After a synchronous active-low reset, txReady, txSent, rxFullA and rxFullB are all 0, and they return to 0 when reset is applied in the middle of a message.
- R2: txStart with at least one port enabled clears txReady and all recorded confirmations at the next clock edge and begins a new message.
- R3: txDone, sampled after a start, raises txSent for exactly one cycle at the next edge. From then on confirmations are awaited.
- R4: With only port A enabled, txReady rises at the clock edge that samples a rising edge on A's selected line. Activity on port B's lines has no effect.
- R5: With only port B enabled, txReady rises at the clock edge that samples a rising edge on B's selected line. Activity on port A's lines has no effect.
- R6: With both ports enabled, txReady rises only once both ports have shown a rising edge on their selected lines, at the edge that samples the later of the two.
- R7: The select value picks which incoming line serves as the port's confirmation: select 0 means line 0 and select 1 means line 1.
- R8: Confirmations are edge-qualified. A line held high from an earlier message does not count, and a rising edge seen before txSent has pulsed is ignored.
- R9: If an enable changes in the middle of a message, completion is re-evaluated against the new set of enabled ports at the next clock edge. Dropping the only unconfirmed port sets txReady.
- R10: With both enables clear, all four flags are held at 0, and txStart, txDone and arrival strobes change nothing.
- R11: rxArrive sets a port's rxFull flag and rxTake clears it; arrival wins if both are high. While the port is disabled, its flag is held at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| enA | input | 1 | Port A far end must confirm |
| enB | input | 1 | Port B far end must confirm |
| selA | input | SEL_W | Confirmation line select for port A |
| selB | input | SEL_W | Confirmation line select for port B |
| sigA | input | SIG_LINES | Incoming status lines on port A |
| sigB | input | SIG_LINES | Incoming status lines on port B |
| txStart | input | 1 | Begin a new message |
| txDone | input | 1 | Message transmission finished |
| rxArriveA | input | 1 | Message arrived on port A |
| rxArriveB | input | 1 | Message arrived on port B |
| rxTakeA | input | 1 | Port A receive buffer read |
| rxTakeB | input | 1 | Port B receive buffer read |
| txReady | output | 1 | All required confirmations received |
| txSent | output | 1 | One-cycle pulse when sending finished |
| rxFullA | output | 1 | Port A receive buffer full |
| rxFullB | output | 1 | Port B receive buffer full |

## Verification
The bench builds the block with SIG_LINES=2, which gives each port a one-bit select and two candidate lines. With this build, the bench can move a port's select to the other line between messages and confirm that a level still high on the old line is not counted. It can also show that an edge on the unselected or disabled port's line is ignored. Single-port, dual-port, mid-message enable change and fully-disabled cases are all reachable with this one build.

// File: rtl/msg_ack_pkg.sv
package msg_ack_pkg;
  localparam int NUM_PORTS = 2;

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_WAIT, ST_DONE} txState_t;

  typedef struct packed {
    logic clrAck;
    logic armAck;
  } ackStrobe_t;
endpackage

// File: rtl/msg_ack_ctrl.sv
module msg_ack_ctrl
  import msg_ack_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       active,
  input  logic       txStart,
  input  logic       txDone,
  input  logic       allDone,
  output ackStrobe_t strobe,
  output logic       txReady,
  output logic       txSent
);
  txState_t state;

  always_comb begin
    strobe.clrAck = active && txStart;
    strobe.armAck = active && (state == ST_WAIT);
  end

  always_ff @(posedge clk) begin
    if (!rstN || !active) begin
      state   <= ST_IDLE;
      txReady <= 1'b0;
      txSent  <= 1'b0;
    end else begin
      txSent <= 1'b0;
      if (txStart) begin
        state   <= ST_SEND;
        txReady <= 1'b0;
      end else begin
        case (state)
          ST_SEND: if (txDone) begin
            txSent <= 1'b1;
            state  <= ST_WAIT;
          end
          ST_WAIT: if (allDone) begin
            txReady <= 1'b1;
            state   <= ST_DONE;
          end
          default: ;
        endcase
      end
    end
  end

  // R3: the sent flag is a single-cycle pulse
  a_r3_sent_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    txSent |=> !txSent);
  // R10: nothing is flagged while the channel is disabled
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !active |=> (!txReady && !txSent));
  // R2: a start drops the ready flag
  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rstN)
    (active && txStart) |=> !txReady);
endmodule

// File: rtl/msg_ack_path.sv
module msg_ack_path
  import msg_ack_pkg::*;
#(
  parameter int SIG_LINES = 2,
  parameter int SEL_W     = 1
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic [NUM_PORTS-1:0]                  en,
  input  logic [NUM_PORTS-1:0][SEL_W-1:0]       sel,
  input  logic [NUM_PORTS-1:0][SIG_LINES-1:0]   sig,
  input  ackStrobe_t                            strobe,
  input  logic [NUM_PORTS-1:0]                  rxArrive,
  input  logic [NUM_PORTS-1:0]                  rxTake,
  output logic                                  allDone,
  output logic [NUM_PORTS-1:0]                  rxFull
);
  logic [NUM_PORTS-1:0] portOk;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [SIG_LINES-1:0] prevSig;
    logic                 edgeHit;
    logic                 seen;

    assign edgeHit  = sig[p][sel[p]] && !prevSig[sel[p]];
    assign portOk[p] = !en[p] || seen || (edgeHit && strobe.armAck);

    always_ff @(posedge clk) begin
      if (!rstN) prevSig <= '0;
      else       prevSig <= sig[p];
    end

    always_ff @(posedge clk) begin
      if (!rstN || strobe.clrAck || !en[p]) seen <= 1'b0;
      else if (strobe.armAck && edgeHit)    seen <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rstN || !en[p])  rxFull[p] <= 1'b0;
      else if (rxArrive[p]) rxFull[p] <= 1'b1;
      else if (rxTake[p])   rxFull[p] <= 1'b0;
    end

    // R11: a disabled port never shows a full buffer
    a_r11_full_held_low: assert property (@(posedge clk) disable iff (!rstN)
      !en[p] |=> !rxFull[p]);
    // R8: a confirmation is only recorded while armed
    a_r8_ack_needs_arm: assert property (@(posedge clk) disable iff (!rstN)
      $rose(seen) |-> $past(strobe.armAck));
  end

  assign allDone = &portOk;
endmodule

// File: rtl/msg_ack_tracker.sv
module msg_ack_tracker
  import msg_ack_pkg::*;
#(
  parameter int SIG_LINES = 2,
  localparam int SEL_W = (SIG_LINES > 1) ? $clog2(SIG_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 enA,
  input  logic                 enB,
  input  logic [SEL_W-1:0]     selA,
  input  logic [SEL_W-1:0]     selB,
  input  logic [SIG_LINES-1:0] sigA,
  input  logic [SIG_LINES-1:0] sigB,
  input  logic                 txStart,
  input  logic                 txDone,
  input  logic                 rxArriveA,
  input  logic                 rxArriveB,
  input  logic                 rxTakeA,
  input  logic                 rxTakeB,
  output logic                 txReady,
  output logic                 txSent,
  output logic                 rxFullA,
  output logic                 rxFullB
);
  ackStrobe_t           strobe;
  logic                 allDone;
  logic [NUM_PORTS-1:0] fullVec;

  msg_ack_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .active  (enA || enB),
    .txStart (txStart),
    .txDone  (txDone),
    .allDone (allDone),
    .strobe  (strobe),
    .txReady (txReady),
    .txSent  (txSent)
  );

  msg_ack_path #(.SIG_LINES(SIG_LINES), .SEL_W(SEL_W)) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .en       ({enB, enA}),
    .sel      ({selB, selA}),
    .sig      ({sigB, sigA}),
    .strobe   (strobe),
    .rxArrive ({rxArriveB, rxArriveA}),
    .rxTake   ({rxTakeB, rxTakeA}),
    .allDone  (allDone),
    .rxFull   (fullVec)
  );

  assign rxFullA = fullVec[0];
  assign rxFullB = fullVec[1];
endmodule

// File: tb/msg_ack_tracker_bench.sv
module msg_ack_tracker_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rstN, enA, enB, selA, selB, txStart, txDone;
  logic [1:0] sigA, sigB;
  logic       rxArriveA, rxArriveB, rxTakeA, rxTakeB;
  logic       txReady, txSent, rxFullA, rxFullB;
  int errors = 0;
  int checks = 0;

  msg_ack_tracker #(.SIG_LINES(2)) u_msg_ack_tracker (
    .clk(clk), .rstN(rstN), .enA(enA), .enB(enB), .selA(selA), .selB(selB),
    .sigA(sigA), .sigB(sigB), .txStart(txStart), .txDone(txDone),
    .rxArriveA(rxArriveA), .rxArriveB(rxArriveB), .rxTakeA(rxTakeA),
    .rxTakeB(rxTakeB), .txReady(txReady), .txSent(txSent),
    .rxFullA(rxFullA), .rxFullB(rxFullB)
  );

  // enA enB | selA selB | sigA | sigB | start done arrA arrB takeA takeB | ready sent fullA fullB
  localparam int NV = 34;
  localparam logic [17:0] VEC [NV] = '{
    18'b10_00_00_00_100000_0000, 18'b10_00_00_00_010000_0100,
    18'b10_00_00_00_000000_0000, 18'b10_00_00_01_000000_0000,
    18'b10_00_01_01_000000_1000, 18'b10_00_01_01_001100_1010,
    18'b10_00_01_01_100000_0010, 18'b10_00_01_01_010000_0110,
    18'b10_00_01_01_000010_0000, 18'b10_10_10_01_000000_1000,
    18'b11_10_10_01_100000_0000, 18'b11_10_10_01_010000_0100,
    18'b11_11_10_11_000000_0000, 18'b11_11_00_11_000000_0000,
    18'b11_11_10_11_000000_1000, 18'b11_11_10_11_100000_0000,
    18'b11_11_10_11_010000_0100, 18'b11_11_00_11_000000_0000,
    18'b11_11_10_11_000000_0000, 18'b10_11_10_11_000000_1000,
    18'b00_11_10_11_000000_0000, 18'b00_11_10_11_101100_0000,
    18'b00_11_10_11_010000_0000, 18'b10_11_10_11_000000_0000,
    18'b01_11_10_11_100000_0000, 18'b01_11_10_11_010000_0100,
    18'b01_11_00_11_000000_0000, 18'b01_11_10_11_000000_0000,
    18'b01_11_10_01_000000_0000, 18'b01_11_10_11_000000_1000,
    18'b01_11_10_01_100000_0000, 18'b01_11_10_11_000000_0000,
    18'b01_11_10_11_010000_0100, 18'b01_11_10_11_000000_0000
  };

  function automatic string rowTag(int i);
    if (i < 3)       return "R2 R3";
    else if (i < 5)  return "R4 R7";
    else if (i < 8)  return "R11";
    else if (i < 10) return "R8 R7";
    else if (i < 15) return "R6";
    else if (i < 20) return "R9";
    else if (i < 24) return "R10";
    else if (i < 30) return "R5";
    else             return "R8";
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: flags(ready,sent,fullA,fullB) got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic idleInputs();
    {enA, enB, selA, selB, sigA, sigB} = '0;
    {txStart, txDone, rxArriveA, rxArriveB, rxTakeA, rxTakeB} = '0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, got hung expected done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    idleInputs();
    #2;
    tick();
    tick();
    check("R1 reset", {txReady, txSent, rxFullA, rxFullB}, 4'b0000);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      {enA, enB, selA, selB, sigA, sigB} = VEC[i][17:10];
      {txStart, txDone, rxArriveA, rxArriveB, rxTakeA, rxTakeB} = VEC[i][9:4];
      tick();
      check($sformatf("%s row %0d", rowTag(i), i),
            {txReady, txSent, rxFullA, rxFullB}, VEC[i][3:0]);
    end

    // R11: full flag on port B cleared by disabling, stays clear on re-enable
    idleInputs();
    enB = 1'b1; rxArriveB = 1'b1;
    tick();
    check("R11 set B", {txReady, txSent, rxFullA, rxFullB}, 4'b0001);
    rxArriveB = 1'b0; enB = 1'b0;
    tick();
    check("R11 disable B", {txReady, txSent, rxFullA, rxFullB}, 4'b0000);
    enB = 1'b1;
    tick();
    check("R11 re-enable B", {txReady, txSent, rxFullA, rxFullB}, 4'b0000);
    // R11: arrival and take together leave the buffer full
    rxArriveB = 1'b1; rxTakeB = 1'b1;
    tick();
    check("R11 arrive wins", {txReady, txSent, rxFullA, rxFullB}, 4'b0001);

    // R1: reset in the middle of a completed message
    idleInputs();
    enA = 1'b1; txStart = 1'b1;
    tick();
    txStart = 1'b0; txDone = 1'b1; rxArriveA = 1'b1;
    tick();
    txDone = 1'b0; rxArriveA = 1'b0; sigA = 2'b01;
    tick();
    check("R4 before reset", {txReady, txSent, rxFullA, rxFullB}, 4'b1010);
    rstN = 1'b0;
    tick();
    check("R1 mid reset", {txReady, txSent, rxFullA, rxFullB}, 4'b0000);
    rstN = 1'b1;
    tick();
    check("R1 after reset", {txReady, txSent, rxFullA, rxFullB}, 4'b0000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule